// File: doc/BRIEF.md
# Burst Beat Ordering and Write Mask Generator

This block turns one memory access into the beat stream of a memory controller that moves data only in fixed four-beat bursts on a 32-bit bus, one word per beat. A request gives a word count, the word where the access starts inside the four-word burst, a direction, an ECC-enable flag and the byte bounds of the first and last words. After the request is accepted, the block steps through the beats. For each beat it reports the word index, whether that beat carries a requested word, a per-byte write mask and a flag on the final beat.

Burst order wraps around from the starting word. An access of four words that starts at a nonzero word uses two bursts: a wrapped one, then one in natural order. Between them the two bursts deliver each requested word exactly once. On writes, beats that carry unrequested words are masked in full. Partial bytes at the edges of the access are masked lane by lane. The exception is ECC mode, where a partial write raises a read-modify-write indication and the merged words are written whole. Reads never mask; they rely on the per-beat valid flag.

Top module: `bbo_burst_seq`

## Requirements
- R1: While reset is applied and after it is released, `req_ready` is 1 and `beat_active`, `beat_valid`, `beat_last`, `seq_rmw`, `beat_word` and `beat_mask` are all 0.
- R2: An accepted request with `req_size_m1` + `req_word_ofs` <= 3 (`req_size_m1` encodes words minus one) produces four beats, starting in the cycle after acceptance. The word indices run from `req_word_ofs` upward and wrap modulo 4. `beat_last` is 1 on the fourth beat only.
- R3: A four-word request (`req_size_m1` = 3) with nonzero `req_word_ofs` produces eight beats. The first four wrap from the offset, and the second four carry words 0,1,2,3. `beat_last` is 1 on the eighth beat only.
- R4: `beat_valid` is 1 exactly on beats that carry a requested word. In the eight-beat case, these are the words at or above the offset in the first burst and the words below the offset in the second burst.
- R5: On a write, every beat with `beat_valid` = 0 has `beat_mask` = 4'hF (bit i covers byte lane i, 1 means the lane is not written).
- R6: On a read, `beat_mask` is 0 on every beat.
- R7: On a write without read-modify-write, the first requested word masks lanes below `req_lead_byte`. The last requested word masks lanes at or above `req_tail_bytes` when `req_tail_bytes` is nonzero (0 means the word is full).
- R8: `seq_rmw` is 1 on every beat of a write with `req_ecc_en` = 1 and nonzero `req_lead_byte` or `req_tail_bytes`. In that case, requested beats have `beat_mask` = 0.
- R9: `seq_rmw` stays 0 for reads, for writes with ECC disabled, and for ECC writes whose lead and tail bytes are both 0.
- R10: A request whose offset plus word count exceeds four, other than a four-word request, raises `req_reject` in the same cycle and starts no beats.
- R11: `req_ready` is 0 while beats are running. Requests made then are ignored and do not alter the running sequence. `req_ready` returns to 1 in the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_size_m1 | input | 2 | Word count minus one |
| req_word_ofs | input | 2 | Starting word inside the burst |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ecc_en | input | 1 | ECC protection enabled |
| req_lead_byte | input | 2 | First valid byte lane of the first word |
| req_tail_bytes | input | 2 | Valid byte count of the last word, 0 means four |
| req_reject | output | 1 | Request has an illegal offset and size combination |
| beat_active | output | 1 | A beat is on the bus this cycle |
| beat_word | output | 2 | Word index of this beat |
| beat_valid | output | 1 | Beat carries a requested word |
| beat_mask | output | 4 | Per-lane write mask, 1 blocks the lane |
| beat_last | output | 1 | Final beat of the sequence |
| seq_rmw | output | 1 | Sequence is the write half of a read-modify-write |

## Verification
The hardest state to reach from the ports is a request that arrives during a running eight-beat sequence and carries different fields. If it leaked into the stored context, the second burst would use the wrong word split. To reach it, the stimulus starts a double burst and then holds `req_valid` high from the second beat onward with changed size, offset, direction and byte bounds. Every remaining beat is compared against the original request, and `req_valid` is dropped only on the final beat. The partial-byte masks of the eight-beat case are also checked. There, the last requested word sits in the second burst, just below the offset.

// File: rtl/bbo_pkg.sv
package bbo_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned LANES     = 4;
  localparam int unsigned POS_W     = $clog2(BURST_LEN);
  localparam int unsigned CNT_W     = POS_W + 1;
  localparam int unsigned LANE_W    = $clog2(LANES);

  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LANES-1:0]  mask_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  typedef struct packed {
    pos_t  size_m1;
    pos_t  ofs;
    logic  wr;
    logic  rmw;
    logic  dbl;
    lane_t lead;
    lane_t tail;
  } seq_ctx_t;
endpackage

// File: rtl/bbo_rst_sync.sv
module bbo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bbo_seq_ctrl.sv
module bbo_seq_ctrl
  import bbo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  pos_t     req_size_m1,
  input  pos_t     req_ofs,
  input  logic     req_write,
  input  logic     req_ecc_en,
  input  lane_t    req_lead,
  input  lane_t    req_tail,
  output logic     req_ready,
  output logic     req_reject,
  output logic     active,
  output logic     last,
  output cnt_t     cnt,
  output seq_ctx_t ctx
);
  localparam cnt_t LAST_ONE = cnt_t'(BURST_LEN - 1);
  localparam cnt_t LAST_TWO = cnt_t'(2 * BURST_LEN - 1);
  localparam pos_t FULL_M1  = pos_t'(BURST_LEN - 1);

  seq_state_e state_q, state_d;
  cnt_t       cnt_q, cnt_d;
  seq_ctx_t   ctx_q, ctx_d;
  logic       ctx_en;
  cnt_t       span;
  logic       fits, full, legal, accept;
  cnt_t       last_cnt;

  assign span     = {1'b0, req_ofs} + {1'b0, req_size_m1};
  assign fits     = span < cnt_t'(BURST_LEN);
  assign full     = req_size_m1 == FULL_M1;
  assign legal    = fits || full;

  assign req_ready  = state_q == ST_IDLE;
  assign accept     = req_valid && req_ready && legal;
  assign req_reject = req_valid && req_ready && !legal;

  assign last_cnt = ctx_q.dbl ? LAST_TWO : LAST_ONE;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ctx_d   = ctx_q;
    ctx_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d       = ST_RUN;
          cnt_d         = '0;
          ctx_en        = 1'b1;
          ctx_d.size_m1 = req_size_m1;
          ctx_d.ofs     = req_ofs;
          ctx_d.wr      = req_write;
          ctx_d.rmw     = req_write && req_ecc_en &&
                          ((req_lead != '0) || (req_tail != '0));
          ctx_d.dbl     = full && (req_ofs != '0);
          ctx_d.lead    = req_lead;
          ctx_d.tail    = req_tail;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + cnt_t'(1);
        if (cnt_q == last_cnt) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_q <= '0;
    else if (ctx_en) ctx_q <= ctx_d;
  end

  assign active = state_q == ST_RUN;
  assign last   = active && (cnt_q == last_cnt);
  assign cnt    = cnt_q;
  assign ctx    = ctx_q;
endmodule

// File: rtl/bbo_beat_decode.sv
module bbo_beat_decode
  import bbo_pkg::*;
(
  input  cnt_t cnt,
  input  pos_t ofs,
  input  pos_t size_m1,
  input  logic dbl,
  output pos_t word,
  output logic wanted,
  output logic first_hit,
  output logic tail_hit
);
  pos_t rel;
  logic second;
  pos_t last_word;
  cnt_t head_cnt;

  assign rel       = cnt[POS_W-1:0];
  assign second    = cnt[POS_W];
  assign last_word = pos_t'(ofs + size_m1);
  assign head_cnt  = cnt_t'(BURST_LEN) - {1'b0, ofs};

  always_comb begin
    if (second) begin
      word   = rel;
      wanted = rel < ofs;
    end else begin
      word   = pos_t'(ofs + rel);
      wanted = dbl ? ({1'b0, rel} < head_cnt) : (rel <= size_m1);
    end
  end

  assign first_hit = wanted && (word == ofs);
  assign tail_hit  = wanted && (word == last_word);
endmodule

// File: rtl/bbo_lane_mask.sv
module bbo_lane_mask
  import bbo_pkg::*;
(
  input  logic  active,
  input  logic  wanted,
  input  logic  first_hit,
  input  logic  tail_hit,
  input  logic  wr,
  input  logic  rmw,
  input  lane_t lead,
  input  lane_t tail,
  output mask_t mask
);
  logic tail_part;

  assign tail_part = tail != '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic head_cut, tail_cut;
    assign head_cut = first_hit && (lane_t'(g) < lead);
    assign tail_cut = tail_hit && tail_part && (lane_t'(g) >= tail);
    always_comb begin
      if (!active || !wr) mask[g] = 1'b0;
      else if (!wanted)   mask[g] = 1'b1;
      else if (rmw)       mask[g] = 1'b0;
      else                mask[g] = head_cut || tail_cut;
    end
  end
endmodule

// File: rtl/bbo_burst_seq.sv
module bbo_burst_seq
  import bbo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_size_m1,
  input  logic [1:0] req_word_ofs,
  input  logic       req_write,
  input  logic       req_ecc_en,
  input  logic [1:0] req_lead_byte,
  input  logic [1:0] req_tail_bytes,
  output logic       req_reject,
  output logic       beat_active,
  output logic [1:0] beat_word,
  output logic       beat_valid,
  output logic [3:0] beat_mask,
  output logic       beat_last,
  output logic       seq_rmw
);
  logic     rst_n_sync;
  logic     active, last;
  cnt_t     cnt;
  seq_ctx_t ctx;
  pos_t     word;
  logic     wanted, first_hit, tail_hit;
  mask_t    mask;

  bbo_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bbo_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .req_valid   (req_valid),
    .req_size_m1 (req_size_m1),
    .req_ofs     (req_word_ofs),
    .req_write   (req_write),
    .req_ecc_en  (req_ecc_en),
    .req_lead    (req_lead_byte),
    .req_tail    (req_tail_bytes),
    .req_ready   (req_ready),
    .req_reject  (req_reject),
    .active      (active),
    .last        (last),
    .cnt         (cnt),
    .ctx         (ctx)
  );

  bbo_beat_decode u_decode (
    .cnt       (cnt),
    .ofs       (ctx.ofs),
    .size_m1   (ctx.size_m1),
    .dbl       (ctx.dbl),
    .word      (word),
    .wanted    (wanted),
    .first_hit (first_hit),
    .tail_hit  (tail_hit)
  );

  bbo_lane_mask u_mask (
    .active    (active),
    .wanted    (wanted),
    .first_hit (first_hit),
    .tail_hit  (tail_hit),
    .wr        (ctx.wr),
    .rmw       (ctx.rmw),
    .lead      (ctx.lead),
    .tail      (ctx.tail),
    .mask      (mask)
  );

  assign beat_active = active;
  assign beat_word   = active ? word : '0;
  assign beat_valid  = active && wanted;
  assign beat_mask   = mask;
  assign beat_last   = last;
  assign seq_rmw     = active && ctx.rmw;
endmodule

// File: rtl/bbo_burst_seq_chk.sv
module bbo_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_reject,
  input logic       req_write,
  input logic       beat_active,
  input logic       beat_valid,
  input logic [3:0] beat_mask,
  input logic       beat_last,
  input logic       seq_rmw
);
  logic dir_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_wr_q <= 1'b0;
    else if (req_valid && req_ready && !req_reject) dir_wr_q <= req_write;
  end

  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !beat_active);

  p_run_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_active && !beat_last) |=> beat_active);

  p_unwanted_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_active && !beat_valid && dir_wr_q) |-> (beat_mask == 4'hF));

  p_read_nomask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_active && !dir_wr_q) |-> (beat_mask == 4'h0));

  p_rmw_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_active && beat_valid && seq_rmw) |-> (beat_mask == 4'h0));

  p_rmw_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_active && !beat_last) |=> $stable(seq_rmw));

  p_rmw_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rmw |-> dir_wr_q);

  p_reject_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |=> !beat_active);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_active |-> !req_ready);

  p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_reject) |=> beat_active);
endmodule

bind bbo_burst_seq bbo_burst_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_reject  (req_reject),
  .req_write   (req_write),
  .beat_active (beat_active),
  .beat_valid  (beat_valid),
  .beat_mask   (beat_mask),
  .beat_last   (beat_last),
  .seq_rmw     (seq_rmw)
);

// File: tb/bbo_burst_seq_bench.sv
`timescale 1ns/1ps
module bbo_burst_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_size_m1 = '0;
  logic [1:0] req_word_ofs = '0;
  logic       req_write = 1'b0;
  logic       req_ecc_en = 1'b0;
  logic [1:0] req_lead_byte = '0;
  logic [1:0] req_tail_bytes = '0;
  logic       req_reject;
  logic       beat_active;
  logic [1:0] beat_word;
  logic       beat_valid;
  logic [3:0] beat_mask;
  logic       beat_last;
  logic       seq_rmw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bbo_burst_seq u_bbo_burst_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size_m1(req_size_m1), .req_word_ofs(req_word_ofs), .req_write(req_write),
    .req_ecc_en(req_ecc_en), .req_lead_byte(req_lead_byte),
    .req_tail_bytes(req_tail_bytes), .req_reject(req_reject),
    .beat_active(beat_active), .beat_word(beat_word), .beat_valid(beat_valid),
    .beat_mask(beat_mask), .beat_last(beat_last), .seq_rmw(seq_rmw)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk(tag, "req_ready", int'(req_ready), 1);
    chk(tag, "beat_active", int'(beat_active), 0);
    chk(tag, "beat_valid", int'(beat_valid), 0);
    chk(tag, "beat_last", int'(beat_last), 0);
    chk(tag, "seq_rmw", int'(seq_rmw), 0);
    chk(tag, "beat_word", int'(beat_word), 0);
    chk(tag, "beat_mask", int'(beat_mask), 0);
  endtask

  // Runs one access; poke holds a changed request during the run.
  task automatic run_seq(input string tag, input int words, input int ofs,
                         input bit wr, input bit ecc, input int lead,
                         input int tail, input bit poke);
    bit dbl = (words == 4) && (ofs != 0);
    int nb = dbl ? 8 : 4;
    bit rmw = wr && ecc && ((lead != 0) || (tail != 0));
    int last_word = (ofs + words - 1) % 4;
    @(negedge clk);
    req_size_m1 = 2'(words - 1); req_word_ofs = 2'(ofs);
    req_write = wr; req_ecc_en = ecc;
    req_lead_byte = 2'(lead); req_tail_bytes = 2'(tail);
    req_valid = 1'b1;
    #0.5;
    chk("R11", {tag, " ready at request"}, int'(req_ready), 1);
    chk("R10", {tag, " no reject"}, int'(req_reject), 0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      int burst = b / 4;
      int pos = b % 4;
      int word = burst ? pos : (ofs + pos) % 4;
      bit want;
      int m = 0;
      if (dbl) want = burst ? (word < ofs) : (word >= ofs);
      else     want = (word >= ofs) && (word < ofs + words);
      if (wr) begin
        if (!want) m = 15;
        else if (!rmw) begin
          for (int l = 0; l < 4; l++) begin
            if (word == ofs && l < lead) m |= (1 << l);
            if (word == last_word && tail != 0 && l >= tail) m |= (1 << l);
          end
        end
      end
      if (poke && b == 1) begin
        req_valid = 1'b1; req_size_m1 = 2'd0; req_word_ofs = 2'd1;
        req_write = ~wr; req_ecc_en = ~ecc; req_lead_byte = 2'd3; req_tail_bytes = 2'd1;
        #0.5;
        chk("R11", {tag, " ready low while busy"}, int'(req_ready), 0);
      end
      if (poke && b == nb - 1) req_valid = 1'b0;
      chk(dbl ? "R3" : "R2", {tag, " active"}, int'(beat_active), 1);
      chk(dbl ? "R3" : "R2", {tag, " word"}, int'(beat_word), word);
      chk(dbl ? "R3" : "R2", {tag, " last"}, int'(beat_last), (b == nb - 1) ? 1 : 0);
      chk("R4", {tag, " valid"}, int'(beat_valid), int'(want));
      chk(!wr ? "R6" : (!want ? "R5" : (rmw ? "R8" : "R7")), {tag, " mask"},
          int'(beat_mask), m);
      chk(rmw ? "R8" : "R9", {tag, " rmw"}, int'(seq_rmw), int'(rmw));
      @(negedge clk);
    end
    chk("R11", {tag, " ready after last"}, int'(req_ready), 1);
    chk("R11", {tag, " inactive after last"}, int'(beat_active), 0);
  endtask

  task automatic test_reset();
    idle_outputs("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_outputs("R1");
  endtask

  task automatic test_single_bursts();
    run_seq("w1o3", 1, 3, 1, 0, 0, 0, 0);
    run_seq("r2o1", 2, 1, 0, 0, 0, 0, 0);
    run_seq("w3o0", 3, 0, 1, 0, 0, 0, 0);
    run_seq("w4o0", 4, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic test_double_bursts();
    run_seq("w4o2", 4, 2, 1, 0, 0, 0, 0);
    run_seq("r4o1", 4, 1, 0, 0, 0, 0, 0);
    run_seq("w4o3p", 4, 3, 1, 0, 1, 2, 0);
  endtask

  task automatic test_partial_bytes();
    run_seq("w2o1p", 2, 1, 1, 0, 2, 3, 0);
    run_seq("w1o2p", 1, 2, 1, 0, 1, 3, 0);
    run_seq("w3o1e", 3, 1, 1, 1, 1, 0, 0);
    run_seq("w4o1e", 4, 1, 1, 1, 0, 2, 0);
    run_seq("w2o0a", 2, 0, 1, 1, 0, 0, 0);
    run_seq("r2o2e", 2, 2, 0, 1, 3, 1, 0);
  endtask

  task automatic test_reject();
    for (int s = 1; s <= 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        if (o + s > 4) begin
          @(negedge clk);
          req_size_m1 = 2'(s - 1); req_word_ofs = 2'(o); req_write = 1'b1;
          req_valid = 1'b1;
          #0.5;
          chk("R10", "reject raised", int'(req_reject), 1);
          @(negedge clk);
          req_valid = 1'b0;
          chk("R10", "no beats after reject", int'(beat_active), 0);
          chk("R10", "still ready", int'(req_ready), 1);
        end
      end
    end
  endtask

  task automatic test_busy();
    run_seq("busy4o2", 4, 2, 1, 0, 1, 1, 1);
    run_seq("busy1o0", 1, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_single_bursts();
    test_double_bursts();
    test_partial_bytes();
    test_reject();
    test_busy();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule